// File: doc/BRIEF.md
# Cascadable Presettable Up/Down Counter

This block is a four-bit synchronous counter that steps up or down by one on each rising clock edge. A parameter selects decimal mode (0 to 9) or binary mode (0 to 15). All state bits change on the same edge, so the outputs never ripple. A synchronous parallel preset loads an arbitrary value and takes priority over counting.

Two active-low enables gate the count, and both must be low for the counter to step. Only the second enable (`en_t_ni`) also feeds the active-low carry output. The carry is decoded combinationally from the state, the direction and `en_t_ni`. Wiring each stage's carry to the next stage's `en_t_ni`, with every `en_p_ni` held low, builds a multi-digit counter with no extra gates. An active-low asynchronous reset clears the state so that simulation starts from a known value.

Top module: `updown_preset_cnt`

## Requirements
- R1: While `rst_ni` is low, `q_o` is 0.
- R2: When `load_ni` is low at a rising edge, `q_o` takes `data_i` on that edge, whatever the enables and the direction are. Bit 0 of `data_i` is the least significant bit.
- R3: When `load_ni` is high and either `en_p_ni` or `en_t_ni` is high at a rising edge, `q_o` keeps its value.
- R4: When `load_ni` is high, both enables are low and `up_i` is 1, `q_o` increments. It wraps from the top value to 0. The top value is 9 in decimal mode and 15 in binary mode.
- R5: When `load_ni` is high, both enables are low and `up_i` is 0, `q_o` decrements. It wraps from 0 to the top value.
- R6: `carry_no` is 0 exactly when `en_t_ni` is 0 and `q_o` sits at the terminal count for the current direction: the top value when `up_i` is 1, or 0 when `up_i` is 0. Otherwise it is 1. It follows its inputs in the same cycle, with no register.
- R7: In decimal mode, a loaded value from 10 to 15 steps to 0 when counting up and to that value minus one when counting down. Its carry stays 1 when counting up.
- R8: In binary mode, all sixteen codes are valid: up wraps from 15 to 0, and down wraps from 0 to 15.
- R9: Three decimal stages, chained carry to `en_t_ni`, count as one three-digit decimal counter from 0 to 999 in both directions. The last stage's carry is 0 only at 999 going up or at 0 going down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_ni | input | 1 | Synchronous preset, active low |
| data_i | input | W | Preset value, bit 0 is LSB |
| en_p_ni | input | 1 | Count enable, active low, does not reach carry |
| en_t_ni | input | 1 | Count enable, active low, gates carry |
| up_i | input | 1 | 1 counts up, 0 counts down |
| q_o | output | W | Counter state |
| carry_no | output | 1 | Terminal-count carry, active low |

## Verification
The bench targets the wrap edges in both directions and in both modes. A wrong modulus would show 10 after 9, or 15 after 0, in decimal mode. Presets while both enables are high catch a load that is wrongly gated by the enables. Holding with only `en_p_ni` high, and then only `en_t_ni` high, catches an enable that was dropped or swapped. Loading illegal decimal codes 10 to 15 exposes next-state logic that runs to 11 or locks up instead of returning to 0. In the three-stage chain, a carry that was registered, or that ignored direction or `en_t_ni`, would make the higher digits step one cycle late or at the wrong count. That shows up at 999 to 0 and at 0 to 999.

// File: rtl/updown_cnt_pkg.sv
package updown_cnt_pkg;
  // largest legal code for the chosen mode
  function automatic int unsigned term_max(int unsigned w, bit decade);
    if (decade) return 9;
    return (1 << w) - 1;
  endfunction
endpackage

// File: rtl/ud_next.sv
module ud_next #(
  parameter int unsigned W      = 4,
  parameter bit          DECADE = 1'b1
) (
  input  logic [W-1:0] q_i,
  output logic [W-1:0] inc_o,
  output logic [W-1:0] dec_o
);
  localparam logic [W-1:0] MAX_Q = W'(updown_cnt_pkg::term_max(W, DECADE));

  if (DECADE) begin : g_dec
    // codes above MAX_Q fold to 0 going up
    assign inc_o = (q_i >= MAX_Q) ? '0 : q_i + 1'b1;
    assign dec_o = (q_i == '0) ? MAX_Q : q_i - 1'b1;
  end else begin : g_bin
    assign inc_o = q_i + 1'b1;
    assign dec_o = q_i - 1'b1;
  end
endmodule

// File: rtl/ud_term.sv
module ud_term #(
  parameter int unsigned W      = 4,
  parameter bit          DECADE = 1'b1
) (
  input  logic [W-1:0] q_i,
  input  logic         up_i,
  input  logic         en_t_ni,
  output logic         carry_no
);
  localparam logic [W-1:0] MAX_Q = W'(updown_cnt_pkg::term_max(W, DECADE));

  logic at_top, at_bot, at_term;

  assign at_top   = (q_i == MAX_Q);
  assign at_bot   = (q_i == '0);
  assign at_term  = up_i ? at_top : at_bot;
  assign carry_no = ~(~en_t_ni & at_term);
endmodule

// File: rtl/updown_preset_cnt.sv
module updown_preset_cnt #(
  parameter int unsigned W      = 4,
  parameter bit          DECADE = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_ni,
  input  logic [W-1:0] data_i,
  input  logic         en_p_ni,
  input  logic         en_t_ni,
  input  logic         up_i,
  output logic [W-1:0] q_o,
  output logic         carry_no
);
  logic [W-1:0] q_q, q_d, inc_w, dec_w;
  logic         step;

  ud_next #(.W(W), .DECADE(DECADE)) u_next (
    .q_i   (q_q),
    .inc_o (inc_w),
    .dec_o (dec_w)
  );

  ud_term #(.W(W), .DECADE(DECADE)) u_term (
    .q_i      (q_q),
    .up_i     (up_i),
    .en_t_ni  (en_t_ni),
    .carry_no (carry_no)
  );

  assign step = ~en_p_ni & ~en_t_ni;

  // preset wins over counting
  always_comb begin
    if (!load_ni)  q_d = data_i;
    else if (step) q_d = up_i ? inc_w : dec_w;
    else           q_d = q_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/updown_preset_cnt_chk.sv
module updown_preset_cnt_chk #(
  parameter int unsigned W      = 4,
  parameter bit          DECADE = 1'b1
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         load_ni,
  input logic [W-1:0] data_i,
  input logic         en_p_ni,
  input logic         en_t_ni,
  input logic         up_i,
  input logic [W-1:0] q_o,
  input logic         carry_no
);
  localparam logic [W-1:0] MAX_Q = W'(updown_cnt_pkg::term_max(W, DECADE));

  always_ff @(posedge clk_i) begin
    if (!rst_ni) AST_RESET_ZERO: assert (q_o == '0); // R1
  end

  AST_LOAD_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_ni |=> q_o == $past(data_i)); // R2
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && (en_p_ni || en_t_ni)) |=> $stable(q_o)); // R3
  AST_UP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && !en_p_ni && !en_t_ni && up_i && q_o < MAX_Q)
      |=> q_o == $past(q_o) + 1'b1); // R4
  AST_DOWN_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && !en_p_ni && !en_t_ni && !up_i && q_o == '0)
      |=> q_o == MAX_Q); // R5
  AST_CARRY_T: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_t_ni |-> carry_no); // R6
endmodule

bind updown_preset_cnt updown_preset_cnt_chk #(.W(W), .DECADE(DECADE)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .load_ni  (load_ni),
  .data_i   (data_i),
  .en_p_ni  (en_p_ni),
  .en_t_ni  (en_t_ni),
  .up_i     (up_i),
  .q_o      (q_o),
  .carry_no (carry_no)
);

// File: tb/sim_updown_preset_cnt.sv
module sim_updown_preset_cnt;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, load_n, p_n, t_n, up;
  logic [3:0] data, q_dec, q_bin;
  logic       c_dec, c_bin;
  // cascade
  logic        cl_n, ct_n, cup;
  logic [11:0] cdata, cq;
  logic [2:0]  cc;

  int checks = 0, errors = 0;
  logic [3:0] m_dec = '0, m_bin = '0;
  int m_cas = 0;

  updown_preset_cnt #(.W(4), .DECADE(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .load_ni(load_n), .data_i(data),
    .en_p_ni(p_n), .en_t_ni(t_n), .up_i(up), .q_o(q_dec), .carry_no(c_dec));

  updown_preset_cnt #(.W(4), .DECADE(1'b0)) u_bin (
    .clk_i(clk), .rst_ni(rst_n), .load_ni(load_n), .data_i(data),
    .en_p_ni(p_n), .en_t_ni(t_n), .up_i(up), .q_o(q_bin), .carry_no(c_bin));

  for (genvar k = 0; k < 3; k++) begin : g_stage
    logic tin;
    if (k == 0) begin : g_first
      assign tin = ct_n;
    end else begin : g_rest
      assign tin = cc[k-1];
    end
    updown_preset_cnt #(.W(4), .DECADE(1'b1)) u_st (
      .clk_i(clk), .rst_ni(rst_n), .load_ni(cl_n), .data_i(cdata[4*k +: 4]),
      .en_p_ni(1'b0), .en_t_ni(tin), .up_i(cup), .q_o(cq[4*k +: 4]),
      .carry_no(cc[k]));
  end

  function automatic logic [3:0] f_next(logic [3:0] q, bit ld_n, logic [3:0] d,
                                        bit p, bit t, bit u, int mx);
    if (!ld_n) return d;
    if (p || t) return q;
    if (u) return (int'(q) >= mx) ? 4'd0 : q + 4'd1;
    return (q == 4'd0) ? 4'(mx) : q - 4'd1;
  endfunction

  function automatic bit f_carry(logic [3:0] q, bit t, bit u, int mx);
    return !(!t && (u ? (int'(q) == mx) : (q == 4'd0)));
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(bit ld_n, logic [3:0] d, bit p, bit t, bit u, string req);
    @(negedge clk);
    load_n = ld_n; data = d; p_n = p; t_n = t; up = u;
    #1;
    chk({req, " R6 carry dec"}, int'(c_dec), int'(f_carry(m_dec, t, u, 9)));
    chk({req, " R6 carry bin"}, int'(c_bin), int'(f_carry(m_bin, t, u, 15)));
    m_dec = f_next(m_dec, ld_n, d, p, t, u, 9);
    m_bin = f_next(m_bin, ld_n, d, p, t, u, 15);
    @(posedge clk);
    #1;
    chk({req, " q dec"}, int'(q_dec), int'(m_dec));
    chk({req, " q bin"}, int'(q_bin), int'(m_bin));
  endtask

  task automatic ccyc(bit ld_n, int val, bit t, bit u, string req);
    @(negedge clk);
    cl_n = ld_n; ct_n = t; cup = u;
    cdata = {4'(val / 100), 4'((val / 10) % 10), 4'(val % 10)};
    #1;
    chk({req, " R9 chain carry"}, int'(cc[2]),
        int'(!(!t && (u ? (m_cas == 999) : (m_cas == 0)))));
    if (!ld_n) m_cas = val;
    else if (!t) m_cas = u ? (m_cas + 1) % 1000 : (m_cas + 999) % 1000;
    @(posedge clk);
    #1;
    chk({req, " R9 chain value"},
        int'(cq[3:0]) + 10 * int'(cq[7:4]) + 100 * int'(cq[11:8]), m_cas);
  endtask

  initial begin
    #(8 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    rst_n = 1'b0; load_n = 1'b1; data = '0; p_n = 1'b1; t_n = 1'b1; up = 1'b1;
    cl_n = 1'b1; ct_n = 1'b1; cup = 1'b1; cdata = '0;
    @(negedge clk); @(negedge clk);
    chk("R1 reset dec", int'(q_dec), 0);
    chk("R1 reset bin", int'(q_bin), 0);
    chk("R1 reset chain", int'(cq), 0);
    rst_n = 1'b1;

    cyc(1'b0, 4'd7, 1'b1, 1'b1, 1'b0, "R2 load with enables off");
    cyc(1'b1, 4'd3, 1'b0, 1'b0, 1'b1, "R4 up");
    cyc(1'b1, 4'd3, 1'b0, 1'b0, 1'b1, "R4 up to top");
    cyc(1'b1, 4'd3, 1'b0, 1'b0, 1'b1, "R4 wrap up");
    cyc(1'b1, 4'd3, 1'b1, 1'b0, 1'b1, "R3 hold p high");
    cyc(1'b1, 4'd3, 1'b0, 1'b1, 1'b0, "R3 hold t high");
    cyc(1'b1, 4'd3, 1'b0, 1'b0, 1'b0, "R5 wrap down");
    cyc(1'b1, 4'd3, 1'b0, 1'b0, 1'b0, "R5 down");
    cyc(1'b0, 4'd12, 1'b0, 1'b0, 1'b1, "R2 load 12");
    cyc(1'b1, 4'd0, 1'b0, 1'b0, 1'b1, "R7 illegal up");
    cyc(1'b0, 4'd12, 1'b0, 1'b0, 1'b0, "R2 load 12 again");
    cyc(1'b1, 4'd0, 1'b0, 1'b0, 1'b0, "R7 illegal down");
    cyc(1'b0, 4'd15, 1'b0, 1'b0, 1'b1, "R2 load 15");
    cyc(1'b1, 4'd0, 1'b0, 1'b0, 1'b1, "R8 binary wrap up");
    cyc(1'b1, 4'd0, 1'b0, 1'b0, 1'b0, "R8 binary wrap down");
    cyc(1'b0, 4'd0, 1'b0, 1'b0, 1'b0, "R2 load 0 counting");
    for (int i = 0; i < 400; i++) begin
      cyc(($urandom % 8) != 0, 4'($urandom), ($urandom % 4) == 0,
          ($urandom % 4) == 0, 1'($urandom), "R3 R4 R5 R7 R8 random");
    end

    ccyc(1'b0, 998, 1'b1, 1'b1, "R9 load 998");
    ccyc(1'b1, 0, 1'b0, 1'b1, "R9 up to 999");
    ccyc(1'b1, 0, 1'b0, 1'b1, "R9 wrap to 0");
    ccyc(1'b1, 0, 1'b0, 1'b0, "R9 wrap to 999");
    ccyc(1'b0, 100, 1'b0, 1'b0, "R9 load 100");
    ccyc(1'b1, 0, 1'b0, 1'b0, "R9 borrow to 99");
    ccyc(1'b1, 0, 1'b1, 1'b0, "R9 hold");
    for (int i = 0; i < 600; i++) begin
      ccyc(($urandom % 32) != 0, int'($urandom % 1000), ($urandom % 6) == 0,
           ($urandom % 64) < 40 ? cup : !cup, "R9 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule